// File: doc/BRIEF.md
# Serial Frame Transmitter with Bus Driver Enable

This block turns one byte into an asynchronous serial frame each time it is asked to. The frame is a low start bit, the eight data bits with the least significant first, a parity bit and one high stop bit. Bit timing comes from an enable that pulses at sixteen times the baud rate. Each bit is held for exactly sixteen of those pulses, and clock cycles without a pulse do not advance the frame.

A driver-enable output is high for exactly the span of the frame, so the block can steer a half-duplex differential transceiver on a shared bus. It rises in the cycle the start bit appears and falls only after the last stop-bit tick. The parity sense, odd or even, is chosen per frame. A one-cycle done pulse marks the end of each frame, and a new request is accepted in that same cycle.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `txLine` is 1, and `drvEn`, `busy` and `donePulse` are 0.
- R2: When `txStart` is high while `busy` is low, the next cycle shows `busy`=1, `drvEn`=1 and `txLine`=0. The start bit lasts 16 tick pulses.
- R3: Frame bits 1 to 8 carry `txData` bit 0 through bit 7 in that order. The data is captured at the accepted strobe.
- R4: Frame bit 9 is the parity bit. It is the XOR of the eight data bits when `parityOdd`=0 (even) and the inverse of that XOR when `parityOdd`=1 (odd). `parityOdd` is captured at the accepted strobe.
- R5: Frame bit 10 is a stop bit of value 1 lasting 16 tick pulses.
- R6: Each frame bit lasts exactly 16 cycles with `tickEn`=1. `txLine` is stable across cycles with `tickEn`=0, so a frame occupies 176 tick periods.
- R7: `drvEn` and `busy` stay high from the start-bit cycle through the cycle of the last stop-bit tick, and are low in the cycle after it.
- R8: A `txStart` that arrives while `busy` is high is ignored, and the frame in progress continues unchanged.
- R9: `donePulse` is high for exactly one cycle, the cycle after the last stop-bit tick. A `txStart` in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Enable pulsing at 16x the baud rate |
| txData | input | 8 | Byte to send |
| txStart | input | 1 | Request strobe |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| txLine | output | 1 | Serial line, high when idle |
| drvEn | output | 1 | Transceiver driver enable, high during the frame |
| busy | output | 1 | Frame in progress |
| donePulse | output | 1 | One-cycle pulse after the stop bit |

## Verification
Every byte value is sent with both parity senses, so a wrong parity polarity, a swapped bit order or a missing data bit shows up as a line mismatch at a known bit slot. Slow tick rates with idle cycles between pulses catch a design that counts clock cycles instead of tick pulses; such a design would make the bits too short. A strobe carrying different data is injected mid-frame to catch a design that restarts or reloads while busy. A back-to-back request in the done cycle catches a design that drops that request or lowers the driver enable early.

// File: rtl/serial_frame_tx_pkg.sv
package serial_frame_tx_pkg;
  typedef struct packed {
    logic load;
    logic shift;
  } dpCtrl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } txState_e;
endpackage

// File: rtl/serial_frame_tx_ctrl.sv
module serial_frame_tx_ctrl
  import serial_frame_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int FRAME_BITS = 11
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tickEn,
  input  logic    txStart,
  output dpCtrl_t strobes,
  output logic    busy,
  output logic    drvEn,
  output logic    donePulse
);
  localparam int TICK_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int BIT_W  = $clog2(FRAME_BITS);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(FRAME_BITS - 1);

  txState_e          state;
  logic [TICK_W-1:0] tickCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              bitEnd;
  logic              lastBit;

  always_comb begin
    bitEnd        = (state == ST_SEND) && tickEn && (tickCnt == TICK_LAST);
    lastBit       = (bitCnt == BIT_LAST);
    strobes.load  = (state == ST_IDLE) && txStart;
    strobes.shift = bitEnd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tickCnt   <= '0;
      bitCnt    <= '0;
      drvEn     <= 1'b0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (txStart) begin
            state   <= ST_SEND;
            drvEn   <= 1'b1;
            tickCnt <= '0;
            bitCnt  <= '0;
          end
        end
        ST_SEND: begin
          if (tickEn) begin
            if (tickCnt == TICK_LAST) begin
              tickCnt <= '0;
              if (lastBit) begin
                state     <= ST_IDLE;
                drvEn     <= 1'b0;
                donePulse <= 1'b1;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_SEND);
endmodule

// File: rtl/serial_frame_tx_dp.sv
module serial_frame_tx_dp
  import serial_frame_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FRAME_BITS = DATA_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtrl_t           strobes,
  input  logic [DATA_W-1:0] txData,
  input  logic              parityOdd,
  output logic              txLine
);
  logic [FRAME_BITS-1:0] shiftReg;
  logic                  parBit;
  logic [FRAME_BITS-1:0] frameWord;

  always_comb begin
    parBit    = (^txData) ^ parityOdd;
    frameWord = {1'b1, parBit, txData, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shiftReg <= '1;
    end else if (strobes.load) begin
      shiftReg <= frameWord;
    end else if (strobes.shift) begin
      shiftReg <= {1'b1, shiftReg[FRAME_BITS-1:1]};
    end
  end

  assign txLine = shiftReg[0];
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import serial_frame_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  input  logic [DATA_W-1:0] txData,
  input  logic              txStart,
  input  logic              parityOdd,
  output logic              txLine,
  output logic              drvEn,
  output logic              busy,
  output logic              donePulse
);
  localparam int FRAME_BITS = DATA_W + 3;

  dpCtrl_t strobes;

  serial_frame_tx_ctrl #(
    .OVERSAMPLE(OVERSAMPLE),
    .FRAME_BITS(FRAME_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tickEn   (tickEn),
    .txStart  (txStart),
    .strobes  (strobes),
    .busy     (busy),
    .drvEn    (drvEn),
    .donePulse(donePulse)
  );

  serial_frame_tx_dp #(
    .DATA_W    (DATA_W),
    .FRAME_BITS(FRAME_BITS)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .txData   (txData),
    .parityOdd(parityOdd),
    .txLine   (txLine)
  );
endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tickEn,
  input logic txStart,
  input logic txLine,
  input logic drvEn,
  input logic busy,
  input logic donePulse
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txLine); // R1

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && txStart) |=> (busy && drvEn && !txLine)); // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tickEn) |=> $stable(txLine)); // R6

  AST_DRV_DROP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drvEn) |-> donePulse); // R7

  AST_BUSY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tickEn) |=> busy); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    donePulse |=> !donePulse); // R9
endmodule

bind serial_frame_tx serial_frame_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tickEn   (tickEn),
  .txStart  (txStart),
  .txLine   (txLine),
  .drvEn    (drvEn),
  .busy     (busy),
  .donePulse(donePulse)
);

// File: tb/serial_frame_tx_bench.sv
`timescale 1ns/1ps
module serial_frame_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickEn = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       txStart = 1'b0;
  logic       parityOdd = 1'b0;
  logic       txLine, drvEn, busy, donePulse;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  serial_frame_tx u_serial_frame_tx (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .txData(txData),
    .txStart(txStart), .parityOdd(parityOdd), .txLine(txLine),
    .drvEn(drvEn), .busy(busy), .donePulse(donePulse)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic expBit(input int b, input logic [7:0] d, input logic odd);
    if (b == 0) return 1'b0;
    if (b <= 8) return d[b-1];
    if (b == 9) return (^d) ^ odd;
    return 1'b1;
  endfunction

  function automatic string bitReq(input int b);
    if (b == 0) return "R2";
    if (b <= 8) return "R3";
    if (b == 9) return "R4";
    return "R5";
  endfunction

  // Entered at a negedge; leaves at the negedge after the done cycle
  // (or at the done cycle itself when chain is set).
  task automatic runFrame(input logic [7:0] d, input logic odd, input int per,
                          input bit inject, input bit chain);
    int errStart;
    int busyCycles;
    errStart   = errors;
    busyCycles = 0;
    txData    = d;
    parityOdd = odd;
    txStart   = 1'b1;
    tickEn    = 1'b0;
    @(negedge clk);
    txStart   = 1'b0;
    txData    = ~d;
    parityOdd = ~odd;
    for (int b = 0; b < 11; b++) begin
      for (int t = 0; t < 16; t++) begin
        for (int k = 0; k < per; k++) begin
          tickEn  = (k == per - 1);
          txStart = inject && (b == 4) && (t == 3) && (k == 0);
          chk(bitReq(b), "line", txLine, expBit(b, d, odd));
          chk("R7", "drvEn", drvEn, 1'b1);
          if (busy) busyCycles++;
          @(negedge clk);
        end
      end
    end
    tickEn  = 1'b0;
    txStart = 1'b0;
    chk("R6", "busy cycles", busyCycles, 176 * per);
    chk("R7", "drvEn after stop", drvEn, 1'b0);
    chk("R7", "busy after stop", busy, 1'b0);
    chk("R9", "done pulse", donePulse, 1'b1);
    chk("R1", "idle line", txLine, 1'b1);
    if (inject) chk("R8", "frame errors with busy strobe", errors - errStart, 0);
    if (!chain) begin
      @(negedge clk);
      chk("R9", "done width", donePulse, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset line", txLine, 1'b1);
    chk("R1", "reset drvEn", drvEn, 1'b0);
    chk("R1", "reset busy", busy, 1'b0);
    chk("R1", "reset done", donePulse, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle line", txLine, 1'b1);
    tickEn = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "ticks while idle", {drvEn, busy, txLine}, 3'b001);
    tickEn = 1'b0;
    for (int i = 0; i < 256; i++) begin
      for (int o = 0; o < 2; o++) begin
        runFrame(8'(i), 1'(o), 1, 1'b0, 1'b0);
      end
    end
    runFrame(8'hA5, 1'b0, 3, 1'b1, 1'b0);
    runFrame(8'h3C, 1'b1, 2, 1'b1, 1'b0);
    runFrame(8'h81, 1'b1, 1, 1'b0, 1'b1);
    runFrame(8'h7E, 1'b0, 1, 1'b0, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule